// File: doc/BRIEF.md
# Configurable Bit-Mask Generator

This unit turns a source word into a mask built around its lowest set bit: the bits below it, that bit alone, or that bit together with those below it, plus other shapes derived from the same formula. The whole family comes from a single expression, `op(first, second)`. A 5-bit control code picks each of its three parts. The first operand is either the source word or its inverse. The second operand is an arithmetic neighbour of the source word: its negation, the word minus one, the word plus one, or the inverse of the word plus one. The combining operation is OR, AND or XOR.

A second word acts as an optional mask. When it is nonzero, the source word is ANDed with it before any arithmetic, and the final result is ANDed with it again. When it is zero, both masking steps are skipped. This lets a caller restrict the search for the lowest set bit to the bit positions it cares about.

The computation is combinational and is captured in a register. The registered result appears one cycle after a valid input, together with a valid flag. The word width is a parameter, and the default is 64 bits.

Top module: `bmask_gen`

## Requirements
- R1: The control code `bm` is read MSB-first. Its two top bits `bm[4:3]` select the combining operation: 0 = OR, 1 = AND, 2 = XOR.
- R2: When `bm[4:3]` equals 3, the registered result is all zeros, whatever the data inputs are.
- R3: Bits `bm[2:1]` select the second operand, computed from the (possibly masked) source word S: 0 = -S, 1 = S-1, 2 = S+1, 3 = ~(S+1).
- R4: Bit `bm[0]` selects the first operand: 0 = ~S, 1 = S.
- R5: When `rb` is nonzero, S = `ra & rb` and the combined value is ANDed with `rb` before it is registered, so no result bit outside `rb` is ever set. Example: `ra`=0x94, `rb`=0xC3 gives 0x43 for `bm`=10 and 0xC3 for `bm`=16. With `ra`=0xD4 and the same `rb`, `bm`=9 gives 0x40.
- R6: When `rb` is zero, S = `ra` and the combined value is registered unmasked.
- R7: All arithmetic on S is two's complement at the word width and wraps around, so -0 = 0 and 0-1 = all ones.
- R8: A result computed from inputs presented with `inValid` high appears on `result`, with `outValid` high, after the next rising clock edge. With `inValid` low, `outValid` drops on the next edge and `result` holds its previous value.
- R9: While `rstN` is low, `outValid` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Inputs are valid this cycle |
| ra | input | WIDTH | Source word |
| rb | input | WIDTH | Optional mask word; zero disables masking |
| bm | input | 5 | Control code: operation, second operand, first operand |
| outValid | output | 1 | `result` holds a new value |
| result | output | WIDTH | Registered mask |

## Verification
Assertions check on every cycle that `outValid` tracks `inValid` one edge later and that the result holds while no input is valid. They also check that an undefined operation code registers zero and that no result bit outside a nonzero mask word is ever set. Only the bench can show that each control code builds the right shape. It does this by sweeping every source word, every control code and a set of mask words on an 8-bit configuration against an arithmetic model. The wraparound corner cases and the named first-set-bit vectors are checked in the bench's directed scenarios.

// File: rtl/bmask_pkg.sv
package bmask_pkg;
  typedef enum logic [1:0] {OP_OR = 2'd0, OP_AND = 2'd1, OP_XOR = 2'd2, OP_NONE = 2'd3} combOp_e;
  typedef enum logic [1:0] {SEC_NEG = 2'd0, SEC_DEC = 2'd1, SEC_INC = 2'd2, SEC_NINC = 2'd3} secOp_e;

  typedef struct packed {
    combOp_e op;
    secOp_e  sec;
    logic    firstTrue;
    logic    load;
  } ctrlStrobes_t;

  localparam int CODE_W = 5;
endpackage

// File: rtl/bmask_ctrl.sv
module bmask_ctrl
  import bmask_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [CODE_W-1:0] bm,
  output ctrlStrobes_t      strobes,
  output logic              outValid
);
  // MSB-first code: [4:3] operation, [2:1] second operand, [0] first operand
  always_comb begin
    strobes.op        = combOp_e'(bm[4:3]);
    strobes.sec       = secOp_e'(bm[2:1]);
    strobes.firstTrue = bm[0];
    strobes.load      = inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_valid_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  always @(negedge clk) begin
    if (!rstN) assert_reset_valid_R9: assert (!outValid);
  end
endmodule

// File: rtl/bmask_datapath.sv
module bmask_datapath
  import bmask_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [WIDTH-1:0] ra,
  input  logic [WIDTH-1:0] rb,
  output logic [WIDTH-1:0] result
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic             maskOn;
  logic [WIDTH-1:0] srcWord, firstOp, secondOp, combined, masked;

  assign maskOn  = |rb;
  assign srcWord = maskOn ? (ra & rb) : ra;
  assign firstOp = strobes.firstTrue ? srcWord : ~srcWord;

  always_comb begin
    unique case (strobes.sec)
      SEC_NEG:  secondOp = '0 - srcWord;
      SEC_DEC:  secondOp = srcWord - ONE;
      SEC_INC:  secondOp = srcWord + ONE;
      default:  secondOp = ~(srcWord + ONE);
    endcase
  end

  always_comb begin
    unique case (strobes.op)
      OP_OR:   combined = firstOp | secondOp;
      OP_AND:  combined = firstOp & secondOp;
      OP_XOR:  combined = firstOp ^ secondOp;
      default: combined = '0;
    endcase
  end

  assign masked = maskOn ? (combined & rb) : combined;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             result <= '0;
    else if (strobes.load) result <= masked;
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(result));
  assert_undef_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.op == OP_NONE) |=> (result == '0));
  assert_mask_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && (|rb)) |=> ((result & ~$past(rb)) == '0));

  always @(negedge clk) begin
    if (!rstN) assert_reset_result_R9: assert (result == '0);
  end
endmodule

// File: rtl/bmask_gen.sv
module bmask_gen
  import bmask_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [WIDTH-1:0] ra,
  input  logic [WIDTH-1:0] rb,
  input  logic [4:0]       bm,
  output logic             outValid,
  output logic [WIDTH-1:0] result
);
  ctrlStrobes_t strobes;

  bmask_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .bm       (bm),
    .strobes  (strobes),
    .outValid (outValid)
  );

  bmask_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .ra      (ra),
    .rb      (rb),
    .result  (result)
  );
endmodule

// File: tb/bmask_gen_test.sv
module bmask_gen_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [W-1:0] ra = '0, rb = '0;
  logic [4:0]   bm = '0;
  logic         outValid;
  logic [W-1:0] result;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  bmask_gen #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ra(ra), .rb(rb), .bm(bm),
    .outValid(outValid), .result(result)
  );

  function automatic int model(int a0, int m, int code);
    int s, f, sec, r, op;
    s  = (m != 0) ? (a0 & m) : a0;
    op = (code >> 3) & 3;
    f  = (code & 1) ? s : (255 - s);
    case ((code >> 1) & 3)
      0: sec = (256 - s) % 256;
      1: sec = (s + 255) % 256;
      2: sec = (s + 1) % 256;
      default: sec = 255 - ((s + 1) % 256);
    endcase
    case (op)
      0: r = f | sec;
      1: r = f & sec;
      2: r = f ^ sec;
      default: r = 0;
    endcase
    if (m != 0) r = r & m;
    return r;
  endfunction

  task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h (ra=%02h rb=%02h bm=%0d)",
               tag, got, exp, ra, rb, bm);
    end
  endtask

  // entered at a negedge; drives, waits one edge, checks at next negedge
  task automatic step(int a0, int m, int code, string tag);
    ra = W'(a0); rb = W'(m); bm = 5'(code); inValid = 1'b1;
    @(negedge clk);
    check({tag, " valid"}, W'(outValid), W'(1));
    check(tag, result, W'(model(a0, m, code)));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int rbSet[4];
    string tag;
    logic [W-1:0] held;
    rbSet = '{0, 8'hFF, 8'hC3, 8'h5A};
    ra = 8'h55; rb = 8'h0F; bm = 5'd3; inValid = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 reset valid", W'(outValid), W'(0));
    check("R9 reset result", result, W'(0));
    inValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // named first-set-bit vectors (R5, R1)
    step(8'h94, 8'hC3, 3,  "R1 or dec");
    step(8'h94, 8'hC3, 11, "R1 and dec");
    step(8'h94, 8'hC3, 19, "R1 xor dec");
    step(8'h94, 8'hC3, 10, "R5 before-first");
    step(8'h94, 8'hC3, 16, "R5 including-first");
    step(8'hD4, 8'hC3, 9,  "R5 only-first");
    step(8'h94, 8'hC3, 27, "R2 undefined op");
    // directed operand selects, no mask
    step(8'h0F, 0, 5'b00101, "R3 inc second");
    step(8'h04, 0, 5'b01000, "R4 inverted first");
    step(8'h04, 0, 5'b01001, "R6 unmasked only-first");
    // wraparound
    step(0, 0, 5'b00011, "R7 zero minus one");
    step(0, 0, 5'b01001, "R7 negate zero");
    step(8'hFF, 0, 5'b00101, "R7 all ones plus one");

    // hold when no valid input
    held = result;
    ra = 8'h01; rb = 8'h00; bm = 5'd3; inValid = 1'b0;
    @(negedge clk);
    check("R8 valid drops", W'(outValid), W'(0));
    check("R8 result held", result, held);
    @(negedge clk);
    check("R8 result still held", result, held);

    // exhaustive sweep
    for (int mi = 0; mi < 4; mi++) begin
      for (int a0 = 0; a0 < 256; a0++) begin
        for (int code = 0; code < 32; code++) begin
          if (((code >> 3) & 3) == 3) tag = "R2 sweep";
          else if (rbSet[mi] != 0)    tag = "R5 sweep";
          else                        tag = "R1 sweep";
          step(a0, rbSet[mi], code, tag);
        end
      end
    end
    inValid = 1'b0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule